// File: doc/BRIEF.md
# Serial Interrupt Host with Message-Signalled Interrupt Conversion

This block is the host end of a single-wire serialized interrupt line that runs on the bus clock. It opens every cycle on the line itself by pulling the line low. It then lets the attached devices report their interrupt requests in a fixed train of phases, and it closes the cycle with a stop frame. After each cycle it compares the reported requests with those of the previous cycle. Each IRQ can be set to edge or level interpretation. Every newly raised request becomes a message-signalled interrupt write request, which goes to the packet layer over a valid/acknowledge handshake.

The write request carries the message address, a flag that tells the packet layer whether to use 64-bit addressing, and a 32-bit payload. The payload holds the configured message value, with the interrupt's message number folded into its low bits. A readable status vector shows the last reported state of every IRQ that is set to level mode. Messages are only produced when message interrupts and bus mastering are both enabled.

Top module: `sirq_msi_bridge`

## Requirements
- R1: The line runs in back-to-back cycles of 59 clocks. Each cycle has a 4-clock start frame with `serirq_oe`=1 and `serirq_out`=0, then 17 released phases of 3 clocks each, then a 2-clock driven-low stop frame, then 2 idle released clocks. The first start frame begins at reset release.
- R2: Phase k, for k from 0 to 15, is sampled in the first clock of that phase, and a low line means IRQ k requests. Phase 16 is the channel-check slot. It is sampled but never produces a message.
- R3: An IRQ whose `cfg_level` bit is 0 (edge mode) produces one message when it was not requesting in the previous cycle and is requesting in this one.
- R4: For an IRQ whose `cfg_level` bit is 1, `lvl_status[k]` holds the request value of the last completed cycle. The bit is 0 for edge-mode IRQs. A message is produced when the status bit rises from 0 to 1.
- R5: Messages are produced only while `cfg_msi_en` and `bm_en` are both 1. Changes detected while either one is 0 are dropped and are not sent later.
- R6: `req_addr` equals {`cfg_addr_hi`, `cfg_addr_lo`}. `req_is64` is 1 exactly when `cfg_addr_hi` is nonzero.
- R7: Let b = min(`cfg_mme`, 4), so that codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 messages, and any code above 4 also selects 16. Payload bits [15:0] equal `cfg_msg_data` with its low b bits replaced by (IRQ number mod 2^b). Payload bits [31:16] are zero.
- R8: Once `req_valid` is high, it stays high with address, flag and payload unchanged until a clock edge at which `req_ack` is high.
- R9: IRQs that become pending together are issued one per handshake, lowest IRQ number first. `req_valid` is low for at least one clock after each accepted request.
- R10: In reset, `req_valid` is 0, `lvl_status` is 0, and the line is driven low for the start frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serirq_in | input | 1 | Sampled value of the serial interrupt line |
| serirq_out | output | 1 | Value driven onto the line |
| serirq_oe | output | 1 | Line driver enable |
| cfg_msi_en | input | 1 | Message interrupts enabled |
| cfg_mme | input | 3 | Enabled message count code |
| cfg_addr_lo | input | 32 | Message address, lower word |
| cfg_addr_hi | input | 32 | Message address, upper word |
| cfg_msg_data | input | 16 | Message value |
| cfg_level | input | 16 | Per-IRQ mode, 1 = level, 0 = edge |
| bm_en | input | 1 | Bus mastering enabled |
| req_valid | output | 1 | Write request offered |
| req_ack | input | 1 | Write request accepted |
| req_addr | output | 64 | Write address |
| req_is64 | output | 1 | Use 64-bit addressing |
| req_data | output | 32 | Write payload |
| lvl_status | output | 16 | Level-mode request status |

## Verification
Two things can happen in the same cycle: the end of a serial cycle can raise several IRQs at once, and a request that is already offered can still be waiting for its acknowledge. The bench provokes this by switching many phases at once, for example eight or fifteen IRQs together, and by acknowledging after a rotating delay of zero to two clocks. The monitor then checks the order and payload of every request against a queue. That queue was filled in ascending IRQ order from a model of the edge rule, the level rule and the aliasing rule. A channel-check-only cycle and cycles with bus mastering disabled must leave the queue and the device silent.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   typedef enum logic [1:0] {
      FR_START = 2'd0,
      FR_PHASE = 2'd1,
      FR_STOP  = 2'd2,
      FR_IDLE  = 2'd3
   } frame_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
   import sirq_pkg::*;
#(
   parameter int NUM_IRQ    = 16,
   parameter int NUM_PHASE  = 17,
   parameter int START_CLKS = 4,
   parameter int PHASE_CLKS = 3,
   parameter int STOP_CLKS  = 2,
   parameter int IDLE_CLKS  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_in,
   output logic               line_out,
   output logic               line_oe,
   output logic [NUM_IRQ-1:0] req_bits,
   output logic               frame_done
);
   localparam int MAXC  = max3(START_CLKS, STOP_CLKS, IDLE_CLKS);
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam int PH_W  = $clog2(NUM_PHASE + 1);
   localparam int SL_W  = $clog2(PHASE_CLKS + 1);

   frame_e             state;
   logic [CNT_W-1:0]   cnt;
   logic [PH_W-1:0]    phase;
   logic [SL_W-1:0]    slot;
   logic [NUM_IRQ-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= FR_START;
         cnt        <= '0;
         phase      <= '0;
         slot       <= '0;
         shadow     <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         case (state)
            FR_START: begin
               if (cnt == CNT_W'(START_CLKS - 1)) begin
                  state <= FR_PHASE;
                  cnt   <= '0;
                  phase <= '0;
                  slot  <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FR_PHASE: begin
               if (slot == '0) begin
                  for (int k = 0; k < NUM_IRQ; k++) begin
                     if (phase == PH_W'(k)) shadow[k] <= ~line_in;
                  end
               end
               if (slot == SL_W'(PHASE_CLKS - 1)) begin
                  slot <= '0;
                  if (phase == PH_W'(NUM_PHASE - 1)) begin
                     state      <= FR_STOP;
                     cnt        <= '0;
                     frame_done <= 1'b1;
                  end else begin
                     phase <= phase + 1'b1;
                  end
               end else begin
                  slot <= slot + 1'b1;
               end
            end
            FR_STOP: begin
               if (cnt == CNT_W'(STOP_CLKS - 1)) begin
                  state <= FR_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               if (cnt == CNT_W'(IDLE_CLKS - 1)) begin
                  state <= FR_START;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assign line_oe  = (state == FR_START) || (state == FR_STOP);
   assign line_out = ~line_oe;
   assign req_bits = shadow;
endmodule

// File: rtl/sirq_irq_detect.sv
module sirq_irq_detect #(
   parameter int NUM_IRQ = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_done,
   input  logic [NUM_IRQ-1:0] req_bits,
   input  logic [NUM_IRQ-1:0] level_mode,
   input  logic               enable,
   output logic [NUM_IRQ-1:0] event_vec,
   output logic [NUM_IRQ-1:0] status
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      logic prev_r;
      logic stat_r;
      logic ev_r;
      logic rise_edge;
      logic rise_lvl;

      assign rise_edge = req_bits[i] & ~prev_r;
      assign rise_lvl  = req_bits[i] & ~stat_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_r <= 1'b0;
            stat_r <= 1'b0;
            ev_r   <= 1'b0;
         end else begin
            ev_r <= 1'b0;
            if (frame_done) begin
               prev_r <= req_bits[i];
               stat_r <= level_mode[i] & req_bits[i];
               ev_r   <= enable & (level_mode[i] ? rise_lvl : rise_edge);
            end
         end
      end

      assign event_vec[i] = ev_r;
      assign status[i]    = stat_r;
   end
endmodule

// File: rtl/sirq_msi_issue.sv
module sirq_msi_issue #(
   parameter int NUM_IRQ   = 16,
   parameter int MSG_W     = 16,
   parameter int MME_W     = 3,
   parameter int ADDR_W    = 64,
   parameter int PAYLOAD_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [NUM_IRQ-1:0]   event_vec,
   input  logic [MME_W-1:0]     mme,
   input  logic [ADDR_W/2-1:0]  addr_lo,
   input  logic [ADDR_W/2-1:0]  addr_hi,
   input  logic [MSG_W-1:0]     msg_data,
   output logic                 req_valid,
   input  logic                 req_ack,
   output logic [ADDR_W-1:0]    req_addr,
   output logic                 req_is64,
   output logic [PAYLOAD_W-1:0] req_data
);
   localparam int IDX_W = $clog2(NUM_IRQ);
   localparam int MAXB  = IDX_W;

   logic [NUM_IRQ-1:0]   pending;
   logic [NUM_IRQ-1:0]   clr_vec;
   logic [IDX_W-1:0]     pick_idx;
   logic                 pick_any;
   logic                 load;
   logic [MSG_W-1:0]     idx_ext;
   logic [MSG_W-1:0]     data_n;
   int                   msg_bits;

   always_comb begin
      pick_idx = '0;
      pick_any = 1'b0;
      for (int k = NUM_IRQ - 1; k >= 0; k--) begin
         if (pending[k]) begin
            pick_idx = IDX_W'(k);
            pick_any = 1'b1;
         end
      end
   end

   assign load = enable && !req_valid && pick_any;

   always_comb begin
      clr_vec = '0;
      if (load) clr_vec[pick_idx] = 1'b1;
   end

   always_comb begin
      msg_bits = (int'(mme) > MAXB) ? MAXB : int'(mme);
      idx_ext  = MSG_W'(pick_idx);
      for (int k = 0; k < MSG_W; k++) begin
         data_n[k] = (k < msg_bits) ? idx_ext[k] : msg_data[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending   <= '0;
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_is64  <= 1'b0;
         req_data  <= '0;
      end else begin
         if (!enable) pending <= '0;
         else         pending <= (pending & ~clr_vec) | event_vec;

         if (load) begin
            req_valid <= 1'b1;
            req_addr  <= {addr_hi, addr_lo};
            req_is64  <= |addr_hi;
            req_data  <= PAYLOAD_W'(data_n);
         end else if (req_valid && req_ack) begin
            req_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sirq_msi_bridge.sv
module sirq_msi_bridge #(
   parameter int NUM_IRQ    = 16,
   parameter int NUM_PHASE  = NUM_IRQ + 1,
   parameter int START_CLKS = 4,
   parameter int PHASE_CLKS = 3,
   parameter int STOP_CLKS  = 2,
   parameter int IDLE_CLKS  = 2,
   parameter int MSG_W      = 16,
   parameter int MME_W      = 3,
   parameter int ADDR_W     = 64,
   parameter int PAYLOAD_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 serirq_in,
   output logic                 serirq_out,
   output logic                 serirq_oe,
   input  logic                 cfg_msi_en,
   input  logic [MME_W-1:0]     cfg_mme,
   input  logic [ADDR_W/2-1:0]  cfg_addr_lo,
   input  logic [ADDR_W/2-1:0]  cfg_addr_hi,
   input  logic [MSG_W-1:0]     cfg_msg_data,
   input  logic [NUM_IRQ-1:0]   cfg_level,
   input  logic                 bm_en,
   output logic                 req_valid,
   input  logic                 req_ack,
   output logic [ADDR_W-1:0]    req_addr,
   output logic                 req_is64,
   output logic [PAYLOAD_W-1:0] req_data,
   output logic [NUM_IRQ-1:0]   lvl_status
);
   if (NUM_IRQ < 2 || NUM_IRQ != (1 << $clog2(NUM_IRQ))) begin : g_bad_irq
      $error("NUM_IRQ must be a power of two of at least 2");
   end
   if (NUM_PHASE < NUM_IRQ) begin : g_bad_phase
      $error("NUM_PHASE must cover every IRQ");
   end
   if (PHASE_CLKS < 2 || START_CLKS < 1 || STOP_CLKS < 1 || IDLE_CLKS < 1) begin : g_bad_timing
      $error("frame timing parameters out of range");
   end
   if (PAYLOAD_W < MSG_W || $clog2(NUM_IRQ) > MSG_W) begin : g_bad_width
      $error("payload or message width too small");
   end
   if ((1 << MME_W) <= $clog2(NUM_IRQ)) begin : g_bad_mme
      $error("MME_W cannot encode all message counts");
   end

   logic                 msg_enable;
   logic [NUM_IRQ-1:0]   req_bits;
   logic                 frame_done;
   logic [NUM_IRQ-1:0]   event_vec;

   assign msg_enable = cfg_msi_en & bm_en;

   sirq_frame_seq #(
      .NUM_IRQ    (NUM_IRQ),
      .NUM_PHASE  (NUM_PHASE),
      .START_CLKS (START_CLKS),
      .PHASE_CLKS (PHASE_CLKS),
      .STOP_CLKS  (STOP_CLKS),
      .IDLE_CLKS  (IDLE_CLKS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_in    (serirq_in),
      .line_out   (serirq_out),
      .line_oe    (serirq_oe),
      .req_bits   (req_bits),
      .frame_done (frame_done)
   );

   sirq_irq_detect #(
      .NUM_IRQ (NUM_IRQ)
   ) u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (frame_done),
      .req_bits   (req_bits),
      .level_mode (cfg_level),
      .enable     (msg_enable),
      .event_vec  (event_vec),
      .status     (lvl_status)
   );

   sirq_msi_issue #(
      .NUM_IRQ   (NUM_IRQ),
      .MSG_W     (MSG_W),
      .MME_W     (MME_W),
      .ADDR_W    (ADDR_W),
      .PAYLOAD_W (PAYLOAD_W)
   ) u_iss (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (msg_enable),
      .event_vec (event_vec),
      .mme       (cfg_mme),
      .addr_lo   (cfg_addr_lo),
      .addr_hi   (cfg_addr_hi),
      .msg_data  (cfg_msg_data),
      .req_valid (req_valid),
      .req_ack   (req_ack),
      .req_addr  (req_addr),
      .req_is64  (req_is64),
      .req_data  (req_data)
   );
endmodule

// File: rtl/sirq_msi_bridge_chk.sv
module sirq_msi_bridge_chk #(
   parameter int MSG_W     = 16,
   parameter int MME_W     = 3,
   parameter int ADDR_W    = 64,
   parameter int PAYLOAD_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_msi_en,
   input logic                 bm_en,
   input logic [MME_W-1:0]     cfg_mme,
   input logic [MSG_W-1:0]     cfg_msg_data,
   input logic                 req_valid,
   input logic                 req_ack,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 req_is64,
   input logic [PAYLOAD_W-1:0] req_data
);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_is64));

   // R9
   ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid);

   // R5
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(cfg_msi_en && bm_en));

   // R6
   addr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_is64 == (req_addr[ADDR_W-1:ADDR_W/2] != '0)));

   // R7
   single_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (cfg_mme == '0) |-> (req_data[MSG_W-1:0] == cfg_msg_data) && (req_data[PAYLOAD_W-1:MSG_W] == '0));
endmodule

bind sirq_msi_bridge sirq_msi_bridge_chk #(
   .MSG_W     (MSG_W),
   .MME_W     (MME_W),
   .ADDR_W    (ADDR_W),
   .PAYLOAD_W (PAYLOAD_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_msi_en   (cfg_msi_en),
   .bm_en        (bm_en),
   .cfg_mme      (cfg_mme),
   .cfg_msg_data (cfg_msg_data),
   .req_valid    (req_valid),
   .req_ack      (req_ack),
   .req_addr     (req_addr),
   .req_is64     (req_is64),
   .req_data     (req_data)
);

// File: tb/sirq_msi_bridge_bench.sv
module sirq_msi_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        serirq_in = 1'b1;
   logic        serirq_out, serirq_oe;
   logic        cfg_msi_en = 1'b0;
   logic [2:0]  cfg_mme = 3'd0;
   logic [31:0] cfg_addr_lo = '0, cfg_addr_hi = '0;
   logic [15:0] cfg_msg_data = '0, cfg_level = '0;
   logic        bm_en = 1'b0;
   logic        req_valid, req_is64;
   logic        req_ack = 1'b0;
   logic [63:0] req_addr;
   logic [31:0] req_data;
   logic [15:0] lvl_status;

   always #2 clk = ~clk;

   sirq_msi_bridge u_sirq_msi_bridge (
      .clk(clk), .rst_n(rst_n), .serirq_in(serirq_in), .serirq_out(serirq_out),
      .serirq_oe(serirq_oe), .cfg_msi_en(cfg_msi_en), .cfg_mme(cfg_mme),
      .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_msg_data(cfg_msg_data),
      .cfg_level(cfg_level), .bm_en(bm_en), .req_valid(req_valid), .req_ack(req_ack),
      .req_addr(req_addr), .req_is64(req_is64), .req_data(req_data), .lvl_status(lvl_status)
   );

   typedef struct {
      logic [63:0] a;
      logic        w64;
      logic [31:0] d;
      int          irq;
   } exp_t;

   exp_t        exp_q[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   logic [16:0] slave_mask = '0;
   logic [16:0] act_mask = '0;
   logic [15:0] m_prev = '0, m_stat = '0;
   logic        n_msi = 0, n_bm = 0;
   logic [2:0]  n_mme = 0;
   logic [31:0] n_lo = 0, n_hi = 0;
   logic [15:0] n_data = 0, n_level = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_payload(input int irq, input int mme, input logic [15:0] md);
      int b;
      logic [15:0] m;
      b = (mme > 4) ? 4 : mme;
      m = 16'((1 << b) - 1);
      return {16'h0, (md & ~m) | (16'(irq) & m)};
   endfunction

   // serial device model: waits for the 4-clock start frame, then answers per phase
   initial begin
      int low_run;
      int pos;
      low_run = 0;
      pos = -1;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            low_run = 0;
            pos = -1;
            serirq_in = 1'b1;
         end else begin
            if (serirq_oe) begin
               low_run++;
               pos = -1;
            end else begin
               if (low_run == 4) begin
                  pos = 0;
                  act_mask = slave_mask;
               end else if (pos >= 0) begin
                  pos++;
               end
               low_run = 0;
            end
            serirq_in = (pos >= 0 && pos % 3 == 0 && pos / 3 < 17 && act_mask[pos / 3]) ? 1'b0 : 1'b1;
         end
      end
   end

   // scoreboard monitor with rotating acknowledge delay
   initial begin
      int wait_ctr;
      int delay;
      wait_ctr = 0;
      delay = 0;
      forever begin
         @(negedge clk);
         req_ack = 1'b0;
         if (rst_n && req_valid) begin
            if (wait_ctr < delay) begin
               wait_ctr++;
            end else begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5", "unexpected request payload", {32'h0, req_data}, 64'h0);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk(req_addr == e.a && req_is64 == e.w64, "R6", "address", req_addr, e.a);
                  chk(req_data == e.d, "R9", "order/payload", {32'h0, req_data}, {32'h0, e.d});
               end
               req_ack = 1'b1;
               wait_ctr = 0;
               delay = (delay + 1) % 3;
            end
         end
      end
   end

   task automatic run_frame(input logic [16:0] m, input string tag);
      logic en;
      int   g;
      en = n_msi && n_bm;
      for (int i = 0; i < 16; i++) begin
         logic samp, ev;
         samp = m[i];
         ev = n_level[i] ? (samp & ~m_stat[i]) : (samp & ~m_prev[i]);
         if (en && ev) begin
            exp_t e;
            e.a = {n_hi, n_lo};
            e.w64 = (n_hi != 0);
            e.d = exp_payload(i, int'(n_mme), n_data);
            e.irq = i;
            exp_q.push_back(e);
         end
         m_prev[i] = samp;
         m_stat[i] = n_level[i] & samp;
      end
      @(negedge clk);
      cfg_msi_en = n_msi;
      bm_en = n_bm;
      cfg_mme = n_mme;
      cfg_addr_lo = n_lo;
      cfg_addr_hi = n_hi;
      cfg_msg_data = n_data;
      cfg_level = n_level;
      slave_mask = m;
      repeat (2 * 59 + 8) @(negedge clk);
      g = 0;
      while (exp_q.size() != 0 && g < 500) begin
         @(negedge clk);
         g++;
      end
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0, tag, "pending expected requests", 64'(exp_q.size()), 64'h0);
      chk(lvl_status == m_stat, "R4", "level status", 64'(lvl_status), 64'(m_stat));
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(req_valid == 1'b0, "R10", "req_valid in reset", 64'(req_valid), 64'h0);
      chk(lvl_status == '0, "R10", "lvl_status in reset", 64'(lvl_status), 64'h0);
      chk(serirq_oe && !serirq_out, "R10", "start frame drive in reset", {62'h0, serirq_oe, serirq_out}, 64'h2);
      @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 start frame is four driven-low clocks
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(serirq_oe == (k < 4) && (serirq_oe ? !serirq_out : 1'b1), "R1", "start frame clock",
             64'(serirq_oe), 64'(k < 4));
      end

      n_msi = 1; n_bm = 1; n_mme = 4; n_hi = 0; n_lo = 32'hFEE0_0000;
      n_data = 16'h4120; n_level = 16'h0000;
      run_frame(17'h00001, "R3");
      run_frame(17'h100A5, "R9");          // IRQ 2,5,7 together plus channel-check
      run_frame(17'h10000, "R2");          // channel-check slot only
      n_mme = 0;
      run_frame(17'h08000, "R7");
      n_mme = 2; n_hi = 32'h0000_0001; n_data = 16'hABCD;
      run_frame(17'h0FFFF, "R6");          // 15 IRQs aliased onto 4 messages
      n_level = 16'hFF00;
      run_frame(17'h0FFFF, "R4");          // level IRQs rise from cleared status
      n_bm = 0;
      run_frame(17'h0FFFF, "R5");
      run_frame(17'h00000, "R5");
      run_frame(17'h00F0F, "R5");          // dropped while disabled
      n_bm = 1;
      run_frame(17'h00F0F, "R5");          // not replayed after enabling
      n_mme = 1; n_data = 16'hBEEF; n_hi = 0;
      run_frame(17'h000F0, "R7");
      n_mme = 7;
      run_frame(17'h0F000, "R7");
      finish_run();
   end
endmodule